// File: doc/BRIEF.md
# Supply Mode Sequencer

This block is the digital power-management controller of an off-line gate-driver chip. It has four modes: a cold start in which the high-voltage charger fills the supply capacitor, a low-power save mode, a full operating mode in which the gate drivers run, and a shutdown mode that handles supply faults. Its inputs are the outputs of the supply and reference comparators, a 1 µs timebase tick, and two logic inputs from the host controller, the high-side and low-side drive commands. Its outputs are the enables of the analog circuits: the high-voltage charger, the reference, the reference current capability, the reference pull-down clamp, the supply regulator, the overcurrent protection and the gate drivers.

In save mode the sequencer holds the supply between two levels by switching the charger on and off. The host enters operating mode by producing a falling edge on the high-side command. This only counts after a settling time in save mode and while the reference is good. The sequencer falls back to save mode when the low-side command stops toggling. It drops to shutdown or to cold start on undervoltage.

Top module: `supply_mode_seq`

## Requirements
- R1: While in the cold-start mode the outputs are: charger on, reference off, reference clamp on, regulator, overcurrent protection and drivers off, and reference high-current mode off. The bench packs the outputs as {gen_en, ref_en, ref_hi_cur, ref_clamp, reg_en, ocp_en, drv_en}, so cold start is 7'b1001000.
- R2: Cold start moves to save mode at the first clock edge at which `vcc_ge_on` is high.
- R3: In save mode the reference is on in low-current mode and the clamp, regulator, protection and drivers are off. The charger turns off at an edge where `vcc_ge_on` is high and turns on at an edge where `vcc_lt_save` is high. Otherwise it holds its state, and it is off on entry to save mode. Save mode is 7'b0100000 with the charger off and 7'b1100000 with it on.
- R4: Save mode moves to cold start at an edge where `vcc_lt_refoff` is high. This takes priority over every other exit.
- R5: Save mode moves to operating mode on a synchronized falling edge of `hs_in`, but only after SETTLE_TICKS ticks in save mode and only while `vref_ok` is high. An edge that comes earlier, or one that comes while `vref_ok` is low, is ignored and not stored.
- R6: In operating mode the outputs are charger off, reference on in high-current mode, clamp off, and regulator, protection and drivers on (7'b0110111).
- R7: Operating mode returns to save mode once IDLE_TICKS ticks pass with no synchronized transition on `ls_in`. Each transition restarts this count.
- R8: Operating mode moves to shutdown at an edge where `vcc_lt_off` or `vref_low` is high. This takes priority over the idle return.
- R9: In shutdown the charger is on and the reference is on in low-current mode, with everything else off (7'b1100000). Shutdown moves to cold start when `vcc_lt_refoff` is high, and otherwise moves to save mode when `vcc_ge_on` is high.
- R10: `hs_in` and `ls_in` pass through SYNC_STAGES flops (default 2). A falling edge of `hs_in` set up before clock edge k changes the mode at edge k+2 with the default setting.
- R11: An active-low `rst_n` puts the block in cold start at once, with the R1 output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| vcc_ge_on | input | 1 | Supply at or above the turn-on level |
| vcc_lt_save | input | 1 | Supply below the save-mode restart level |
| vcc_lt_off | input | 1 | Supply below the turn-off level |
| vcc_lt_refoff | input | 1 | Supply below the reference-off level |
| vref_ok | input | 1 | Reference above 3.0 V |
| vref_low | input | 1 | Reference below 2.0 V |
| hs_in | input | 1 | High-side drive command from the host |
| ls_in | input | 1 | Low-side drive command from the host |
| gen_en | output | 1 | High-voltage charger enable |
| ref_en | output | 1 | Reference enable |
| ref_hi_cur | output | 1 | Reference high-current mode |
| ref_clamp | output | 1 | Reference pull-down clamp enable |
| reg_en | output | 1 | Supply regulator enable |
| ocp_en | output | 1 | Overcurrent protection enable |
| drv_en | output | 1 | Gate driver enable |

## Verification
The assertions assume that the comparator flags are already synchronous to `clk` and physically consistent. For example, `vcc_ge_on` is never high together with `vcc_lt_save`, `vcc_lt_off` or `vcc_lt_refoff`, and `vref_ok` and `vref_low` are never high together. They also assume that `tick_1us` is a single-cycle pulse. The stimulus changes the flags only as whole consistent supply levels, drives a tick every fifth clock, and changes `hs_in` and `ls_in` at most once per stimulus step, far apart compared with the synchronizer depth.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } smode_e;

  typedef struct packed {
    logic gen;
    logic ref_on;
    logic ref_hi;
    logic clamp;
    logic regu;
    logic ocp;
    logic drv;
  } sout_t;

  // counter width able to hold the value limit
  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // per-mode output decode; save mode takes the charger state from the hysteresis flop
  function automatic sout_t mode_outputs(smode_e m, logic gen_hyst);
    sout_t o;
    o = '0;
    unique case (m)
      ST_BOOT: begin
        o.gen   = 1'b1;
        o.clamp = 1'b1;
      end
      ST_SAVE: begin
        o.gen    = gen_hyst;
        o.ref_on = 1'b1;
      end
      ST_RUN: begin
        o.ref_on = 1'b1;
        o.ref_hi = 1'b1;
        o.regu   = 1'b1;
        o.ocp    = 1'b1;
        o.drv    = 1'b1;
      end
      ST_FAULT: begin
        o.gen    = 1'b1;
        o.ref_on = 1'b1;
      end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/smseq_edge_sync.sv
module smseq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], din};
  end

  assign lvl      = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];
endmodule

// File: rtl/smseq_tick_timer.sv
module smseq_tick_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic done
);
  import smseq_pkg::*;

  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (tick && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIM);
endmodule

// File: rtl/smseq_gen_hyst.sv
module smseq_gen_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic at_on,
  input  logic below_save,
  output logic gen_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gen_q <= 1'b0;
    else if (!active)    gen_q <= 1'b0;
    else if (at_on)      gen_q <= 1'b0;
    else if (below_save) gen_q <= 1'b1;
  end
endmodule

// File: rtl/supply_mode_seq.sv
module supply_mode_seq #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SETTLE_TICKS = 10,
  parameter int unsigned IDLE_TICKS   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1us,
  input  logic vcc_ge_on,
  input  logic vcc_lt_save,
  input  logic vcc_lt_off,
  input  logic vcc_lt_refoff,
  input  logic vref_ok,
  input  logic vref_low,
  input  logic hs_in,
  input  logic ls_in,
  output logic gen_en,
  output logic ref_en,
  output logic ref_hi_cur,
  output logic ref_clamp,
  output logic reg_en,
  output logic ocp_en,
  output logic drv_en
);
  import smseq_pkg::*;

  localparam int unsigned NCMD = 2;

  smode_e mode_q, mode_d;
  sout_t  outs;

  logic [NCMD-1:0] cmd_in, cmd_lvl, cmd_prev;
  logic hs_fall_w, ls_edge_w;
  logic settle_done_w, idle_done_w;
  logic gen_hyst_w;

  assign cmd_in = {ls_in, hs_in};

  // one synchronizer per host command
  for (genvar g = 0; g < NCMD; g++) begin : g_sync
    smseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cmd_in[g]),
      .lvl      (cmd_lvl[g]),
      .lvl_prev (cmd_prev[g])
    );
  end

  assign hs_fall_w = cmd_prev[0] & ~cmd_lvl[0];
  assign ls_edge_w = cmd_prev[1] ^ cmd_lvl[1];

  smseq_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1us),
    .clr   (mode_q != ST_SAVE),
    .done  (settle_done_w)
  );

  smseq_tick_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1us),
    .clr   ((mode_q != ST_RUN) || ls_edge_w),
    .done  (idle_done_w)
  );

  smseq_gen_hyst u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (mode_q == ST_SAVE),
    .at_on      (vcc_ge_on),
    .below_save (vcc_lt_save),
    .gen_q      (gen_hyst_w)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      ST_BOOT: begin
        if (vcc_ge_on) mode_d = ST_SAVE;
      end
      ST_SAVE: begin
        if (vcc_lt_refoff)                               mode_d = ST_BOOT;
        else if (hs_fall_w && settle_done_w && vref_ok)  mode_d = ST_RUN;
      end
      ST_RUN: begin
        if (vcc_lt_off || vref_low) mode_d = ST_FAULT;
        else if (idle_done_w)       mode_d = ST_SAVE;
      end
      ST_FAULT: begin
        if (vcc_lt_refoff)  mode_d = ST_BOOT;
        else if (vcc_ge_on) mode_d = ST_SAVE;
      end
      default: mode_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= ST_BOOT;
    else        mode_q <= mode_d;
  end

  assign outs       = mode_outputs(mode_q, gen_hyst_w);
  assign gen_en     = outs.gen;
  assign ref_en     = outs.ref_on;
  assign ref_hi_cur = outs.ref_hi;
  assign ref_clamp  = outs.clamp;
  assign reg_en     = outs.regu;
  assign ocp_en     = outs.ocp;
  assign drv_en     = outs.drv;
endmodule

// File: rtl/smseq_chk.sv
module smseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_ge_on,
  input logic       vcc_lt_save,
  input logic       vcc_lt_off,
  input logic       vcc_lt_refoff,
  input logic       vref_ok,
  input logic       vref_low,
  input logic [1:0] mode,
  input logic       hs_fall,
  input logic       settle_done,
  input logic       idle_done,
  input logic       gen_en,
  input logic       ref_en,
  input logic       ref_hi_cur,
  input logic       ref_clamp,
  input logic       reg_en,
  input logic       ocp_en,
  input logic       drv_en
);
  import smseq_pkg::*;

  p_boot_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clamp |-> (gen_en && !ref_en && !drv_en && !reg_en && !ocp_en));

  p_boot_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_BOOT && vcc_ge_on) |=> (mode == ST_SAVE));

  p_gen_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SAVE && vcc_ge_on && !vcc_lt_refoff) |=> !gen_en);

  p_gen_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SAVE && vcc_lt_save && !vcc_ge_on && !vcc_lt_refoff &&
     !(hs_fall && settle_done && vref_ok)) |=> gen_en);

  p_save_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SAVE && vcc_lt_refoff) |=> ref_clamp);

  p_run_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ($past(hs_fall) && $past(settle_done) && $past(vref_ok)));

  p_run_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (reg_en && ocp_en && ref_hi_cur && ref_en && !gen_en && !ref_clamp));

  p_idle_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv_en) && !$past(vcc_lt_off) && !$past(vref_low)) |->
      ($past(idle_done) && ref_en && !gen_en));

  p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && (vcc_lt_off || vref_low)) |=> (!drv_en && gen_en && ref_en && !ref_hi_cur));

  p_fault_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_FAULT && vcc_lt_refoff) |=> ref_clamp);
endmodule

bind supply_mode_seq smseq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vcc_ge_on     (vcc_ge_on),
  .vcc_lt_save   (vcc_lt_save),
  .vcc_lt_off    (vcc_lt_off),
  .vcc_lt_refoff (vcc_lt_refoff),
  .vref_ok       (vref_ok),
  .vref_low      (vref_low),
  .mode          (mode_q),
  .hs_fall       (hs_fall_w),
  .settle_done   (settle_done_w),
  .idle_done     (idle_done_w),
  .gen_en        (gen_en),
  .ref_en        (ref_en),
  .ref_hi_cur    (ref_hi_cur),
  .ref_clamp     (ref_clamp),
  .reg_en        (reg_en),
  .ocp_en        (ocp_en),
  .drv_en        (drv_en)
);

// File: tb/supply_mode_seq_tb.sv
`timescale 1ns/1ps
module supply_mode_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1us = 1'b0;
  logic vcc_ge_on, vcc_lt_save, vcc_lt_off, vcc_lt_refoff, vref_ok, vref_low;
  logic hs_in, ls_in;
  logic gen_en, ref_en, ref_hi_cur, ref_clamp, reg_en, ocp_en, drv_en;

  int total = 0;
  int bad = 0;
  int tick_div = 0;

  always #10 clk = ~clk;  // 50 MHz

  // one tick every fifth clock
  always @(negedge clk) begin
    tick_div = (tick_div == 4) ? 0 : tick_div + 1;
    tick_1us <= (tick_div == 0);
  end

  supply_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
    .vcc_ge_on(vcc_ge_on), .vcc_lt_save(vcc_lt_save), .vcc_lt_off(vcc_lt_off),
    .vcc_lt_refoff(vcc_lt_refoff), .vref_ok(vref_ok), .vref_low(vref_low),
    .hs_in(hs_in), .ls_in(ls_in),
    .gen_en(gen_en), .ref_en(ref_en), .ref_hi_cur(ref_hi_cur), .ref_clamp(ref_clamp),
    .reg_en(reg_en), .ocp_en(ocp_en), .drv_en(drv_en)
  );

  // expected output codes {gen, ref, hi, clamp, reg, ocp, drv}
  localparam logic [6:0] O_BOOT = 7'b1001000;
  localparam logic [6:0] O_SV0  = 7'b0100000;
  localparam logic [6:0] O_SV1  = 7'b1100000;
  localparam logic [6:0] O_RUN  = 7'b0110111;
  localparam logic [6:0] O_FLT  = 7'b1100000;

  // flags {ge_on, lt_save, lt_off, lt_refoff, vref_ok, vref_low}
  // vector {flags[6], hs, ls, wait[12], expect[7], req[4]}
  localparam int NV = 28;
  localparam logic [30:0] VEC [NV] = '{
    {6'b011100, 1'b1, 1'b0, 12'd3,   O_BOOT, 4'd1},  // R1 low supply
    {6'b011000, 1'b1, 1'b0, 12'd3,   O_BOOT, 4'd1},  // R1
    {6'b100000, 1'b1, 1'b0, 12'd1,   O_SV0,  4'd2},  // R2 turn-on reached
    {6'b000000, 1'b1, 1'b0, 12'd2,   O_SV0,  4'd3},  // R3 hold off
    {6'b010000, 1'b1, 1'b0, 12'd1,   O_SV1,  4'd3},  // R3 below save level
    {6'b000000, 1'b1, 1'b0, 12'd2,   O_SV1,  4'd3},  // R3 hold on
    {6'b100000, 1'b1, 1'b0, 12'd1,   O_SV0,  4'd3},  // R3 off at turn-on
    {6'b000010, 1'b0, 1'b0, 12'd10,  O_SV0,  4'd5},  // R5 early edge ignored
    {6'b000010, 1'b1, 1'b0, 12'd300, O_SV0,  4'd5},  // R5 no fall, no entry
    {6'b000010, 1'b0, 1'b0, 12'd2,   O_SV0,  4'd10}, // R10 not yet
    {6'b000010, 1'b0, 1'b0, 12'd1,   O_RUN,  4'd10}, // R10 at edge k+2
    {6'b000010, 1'b0, 1'b1, 12'd300, O_RUN,  4'd7},  // R7 activity
    {6'b000010, 1'b0, 1'b0, 12'd300, O_RUN,  4'd7},  // R7 activity
    {6'b000010, 1'b0, 1'b1, 12'd300, O_RUN,  4'd7},  // R7 activity
    {6'b000010, 1'b0, 1'b1, 12'd600, O_SV0,  4'd7},  // R7 idle return
    {6'b000010, 1'b1, 1'b1, 12'd100, O_SV0,  4'd5},  // R5
    {6'b000010, 1'b0, 1'b1, 12'd4,   O_RUN,  4'd6},  // R6 outputs in run
    {6'b000001, 1'b0, 1'b1, 12'd1,   O_FLT,  4'd8},  // R8 reference low
    {6'b000010, 1'b0, 1'b1, 12'd3,   O_FLT,  4'd9},  // R9 stays in shutdown
    {6'b100010, 1'b0, 1'b1, 12'd1,   O_SV0,  4'd9},  // R9 back to save
    {6'b000010, 1'b1, 1'b1, 12'd100, O_SV0,  4'd5},  // R5
    {6'b000010, 1'b0, 1'b1, 12'd4,   O_RUN,  4'd5},  // R5 entry
    {6'b011010, 1'b0, 1'b1, 12'd1,   O_FLT,  4'd8},  // R8 supply below off
    {6'b011110, 1'b0, 1'b1, 12'd1,   O_BOOT, 4'd9},  // R9 to cold start
    {6'b100010, 1'b0, 1'b1, 12'd1,   O_SV0,  4'd2},  // R2
    {6'b000000, 1'b1, 1'b1, 12'd100, O_SV0,  4'd5},  // R5
    {6'b000000, 1'b0, 1'b1, 12'd10,  O_SV0,  4'd5},  // R5 reference not good
    {6'b011100, 1'b0, 1'b1, 12'd1,   O_BOOT, 4'd4}   // R4 save drop
  };

  function automatic logic [6:0] outs_now();
    return {gen_en, ref_en, ref_hi_cur, ref_clamp, reg_en, ocp_en, drv_en};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    total++;
    if (outs_now() !== exp) begin
      bad++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, outs_now(), exp, $time);
    end
  endtask

  task automatic apply(input logic [5:0] fl, input logic hs, input logic ls);
    {vcc_ge_on, vcc_lt_save, vcc_lt_off, vcc_lt_refoff, vref_ok, vref_low} = fl;
    hs_in = hs;
    ls_in = ls;
  endtask

  task automatic step(input logic [5:0] fl, input logic hs, input logic ls,
                      input int wt, input logic [6:0] exp, input string req);
    @(negedge clk);
    apply(fl, hs, ls);
    repeat (wt) @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    apply(6'b011100, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 during reset", O_BOOT);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", O_BOOT);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30:25], VEC[i][24], VEC[i][23], int'(VEC[i][22:11]),
           VEC[i][10:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R8 priority over a simultaneous idle timeout is covered by assertion; here reset in run
    step(6'b100010, 1'b1, 1'b1, 1,   O_SV0, "R2 before reset test");
    step(6'b000010, 1'b1, 1'b1, 100, O_SV0, "R5 settle before reset test");
    step(6'b000010, 1'b0, 1'b1, 4,   O_RUN, "R6 run before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async reset in run", O_BOOT);
    @(negedge clk);
    apply(6'b011100, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 cold start after reset", O_BOOT);
    step(6'b100010, 1'b1, 1'b0, 1, O_SV0, "R2 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule